// File: doc/BRIEF.md
# Serial SAR Converter Readout Controller

This block is the host-side master for a 16-bit successive-approximation converter that talks over three wires: an active-low select, a data clock and a serial data return. It makes the data clock by dividing the system clock. While the select line is high the converter is powered down, so the block holds select high between frames. A frame starts on a software pulse or on a periodic rate tick, and each frame returns one signed result.

During a frame the block produces exactly 22 data-clock rising edges. It reads the return line only on those rising edges, because the converter changes it on falling edges. The first five edges fall inside the converter's sampling window and are not used. The sixth edge carries a guard bit that must read 0. The last sixteen edges carry the result, most significant bit first. Select goes high on the falling edge that follows the 22nd rise. The line then stays idle for at least one full data-clock period before another frame can begin.

The result arrives with a one-cycle strobe, together with a flag that reports a bad guard bit.

Top module: `sar_rd_ctrl`

## Requirements
- R1: After reset, `cs_n_o` is 1, `sclk_o` is 0, `sample_vld_o` is 0, `sample_o` is 0 and `null_err_o` is 0.
- R2: If the block is idle at a clock edge where `start_i` is 1 or a rate tick occurs, `cs_n_o` falls at that edge. `sclk_o` is 0 whenever `cs_n_o` is 1.
- R3: The data-clock half period is max(`half_div_i`, MIN_DIV)+1 system cycles (MIN_DIV defaults to 1). The value is captured when the frame starts, and later changes to `half_div_i` do not affect that frame. The first rise of `sclk_o` comes one half period after `cs_n_o` falls.
- R4: Each frame has exactly 22 rising edges of `sclk_o`. `cs_n_o` rises at the same clock edge as the falling `sclk_o` edge that follows the 22nd rise.
- R5: `miso_i` is sampled only at `sclk_o` rising edges. Rises 1 to 5 are ignored, rise 6 is the guard bit, and rises 7 to 22 give bits 15 down to 0. `sample_o` holds this word as two's complement.
- R6: `sample_vld_o` is high for exactly one system cycle. It goes high at the same clock edge as the 22nd rise of `sclk_o`, and `sample_o` carries the new word in that cycle.
- R7: `null_err_o` is updated together with each strobe and equals the guard bit that was read (1 means error). The word is delivered whether or not the guard bit is bad.
- R8: Between frames, `cs_n_o` stays high for 2*(half period)+1 cycles when a trigger is waiting. A `start_i` pulse that arrives during a frame or during the idle gap is dropped.
- R9: When `auto_en_i` is 1, a rate tick occurs every `rate_i`+1 cycles. A tick that arrives while a frame or gap is in progress is dropped, so frames start on tick boundaries.
- R10: While `cs_n_o` is high, activity on `miso_i` produces no strobe and leaves `sample_o` unchanged.
- R11: A `start_i` pulse and a rate tick at the same clock edge start exactly one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a single frame |
| auto_en_i | input | 1 | Enable periodic rate ticks |
| rate_i | input | RATE_W | Tick interval minus one, in system cycles |
| half_div_i | input | DIV_W | Data-clock half period minus one, in system cycles |
| miso_i | input | 1 | Serial data returned by the converter |
| cs_n_o | output | 1 | Active-low converter select; high means power-down |
| sclk_o | output | 1 | Data clock to the converter |
| sample_o | output | DATA_W | Latest result, signed |
| sample_vld_o | output | 1 | One-cycle strobe for a new result |
| null_err_o | output | 1 | Guard bit was not 0 on the latest result |

## Verification
Two triggers can reach the idle sequencer in the same cycle: the software start pulse and the rate tick. The bench enables the tick counter from zero at a known clock edge and then raises `start_i` exactly `rate_i` cycles later, so that both triggers meet at one edge. The result is judged by counting select falls and strobes over a window shorter than the next tick: both counts must be one, and the word must match the stimulus. A second overlap is also checked: a start pulse that lands in the idle gap just after select rises, which must not open a new frame.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_GAP   = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    SLOT_WINDOW = 2'd0,
    SLOT_GUARD  = 2'd1,
    SLOT_DATA   = 2'd2,
    SLOT_LAST   = 2'd3
  } slot_e;

  // Effective half-period divider after applying the lower clamp.
  function automatic int unsigned eff_div(input int unsigned req,
                                          input int unsigned floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  // Total rising edges in one frame.
  function automatic int unsigned frame_edges(input int unsigned skip,
                                              input int unsigned width);
    return skip + 1 + width;
  endfunction

  // Meaning of the rising edge with 1-based number idx.
  function automatic slot_e classify(input int unsigned idx,
                                     input int unsigned skip,
                                     input int unsigned width);
    if (idx <= skip)                          return SLOT_WINDOW;
    if (idx == skip + 1)                      return SLOT_GUARD;
    if (idx == frame_edges(skip, width))      return SLOT_LAST;
    return SLOT_DATA;
  endfunction

endpackage

// File: rtl/sar_rd_rate_tick.sv
module sar_rd_rate_tick #(
  parameter int RATE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [RATE_W-1:0] interval_i,
  output logic              tick_o
);

  logic [RATE_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == interval_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sar_rd_sclk_gen.sv
module sar_rd_sclk_gen #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             count_en_i,
  input  logic             toggle_en_i,
  output logic             sclk_o,
  output logic             half_done_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] hcnt_q;
  logic             sclk_q;
  logic [DIV_W-1:0] div_eff;

  assign div_eff     = DIV_W'(sar_rd_pkg::eff_div(32'(div_i), MIN_DIV));
  assign half_done_o = count_en_i && (hcnt_q == div_q);
  assign rise_o      = half_done_o && toggle_en_i && !sclk_q;
  assign fall_o      = half_done_o && toggle_en_i &&  sclk_q;
  assign sclk_o      = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(MIN_DIV);
      hcnt_q <= '0;
      sclk_q <= 1'b0;
    end else if (load_i) begin
      div_q  <= div_eff;
      hcnt_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      if (count_en_i) begin
        hcnt_q <= half_done_o ? '0 : hcnt_q + 1'b1;
      end
      if (toggle_en_i && half_done_o) begin
        sclk_q <= ~sclk_q;
      end
    end
  end

endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq #(
  parameter int CNT_W      = 5,
  parameter int FRAME_CLKS = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigger_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             half_done_i,
  output logic             cs_n_o,
  output logic             load_o,
  output logic             count_en_o,
  output logic             toggle_en_o,
  output logic [CNT_W-1:0] rise_idx_o,
  output logic             frame_end_o,
  output logic             busy_o
);

  import sar_rd_pkg::*;

  seq_state_e       state_q;
  logic [CNT_W-1:0] rcnt_q;
  logic             gap_half_q;
  logic             cs_n_q;

  assign load_o      = (state_q == SEQ_IDLE) && trigger_i;
  assign count_en_o  = (state_q != SEQ_IDLE);
  assign toggle_en_o = (state_q == SEQ_SHIFT);
  assign busy_o      = (state_q != SEQ_IDLE);
  assign rise_idx_o  = rcnt_q + 1'b1;
  assign frame_end_o = (state_q == SEQ_SHIFT) && fall_i &&
                       (rcnt_q == CNT_W'(FRAME_CLKS));
  assign cs_n_o      = cs_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      rcnt_q     <= '0;
      gap_half_q <= 1'b0;
      cs_n_q     <= 1'b1;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (trigger_i) begin
            state_q <= SEQ_SHIFT;
            rcnt_q  <= '0;
            cs_n_q  <= 1'b0;
          end
        end
        SEQ_SHIFT: begin
          if (rise_i) begin
            rcnt_q <= rcnt_q + 1'b1;
          end
          if (frame_end_o) begin
            state_q    <= SEQ_GAP;
            gap_half_q <= 1'b0;
            cs_n_q     <= 1'b1;
          end
        end
        SEQ_GAP: begin
          if (half_done_i) begin
            if (gap_half_q) begin
              state_q <= SEQ_IDLE;
            end else begin
              gap_half_q <= 1'b1;
            end
          end
        end
        default: begin
          state_q <= SEQ_IDLE;
          cs_n_q  <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/sar_rd_shifter.sv
module sar_rd_shifter #(
  parameter int DATA_W    = 16,
  parameter int SKIP_CLKS = 5,
  parameter int CNT_W     = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rise_i,
  input  logic [CNT_W-1:0]         rise_idx_i,
  input  logic                     sdi_i,
  output logic signed [DATA_W-1:0] sample_o,
  output logic                     vld_o,
  output logic                     err_o
);

  import sar_rd_pkg::*;

  logic [DATA_W-2:0] shreg_q;
  logic              guard_q;
  slot_e             slot;

  assign slot = classify(32'(rise_idx_i), SKIP_CLKS, DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      guard_q  <= 1'b0;
      sample_o <= '0;
      vld_o    <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (rise_i) begin
        case (slot)
          SLOT_GUARD: guard_q <= sdi_i;
          SLOT_DATA:  shreg_q <= {shreg_q[DATA_W-3:0], sdi_i};
          SLOT_LAST: begin
            sample_o <= $signed({shreg_q, sdi_i});
            vld_o    <= 1'b1;
            err_o    <= guard_q;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl #(
  parameter int DATA_W    = 16,
  parameter int SKIP_CLKS = 5,
  parameter int DIV_W     = 8,
  parameter int MIN_DIV   = 1,
  parameter int RATE_W    = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     auto_en_i,
  input  logic [RATE_W-1:0]        rate_i,
  input  logic [DIV_W-1:0]         half_div_i,
  input  logic                     miso_i,
  output logic                     cs_n_o,
  output logic                     sclk_o,
  output logic signed [DATA_W-1:0] sample_o,
  output logic                     sample_vld_o,
  output logic                     null_err_o
);

  localparam int FRAME_CLKS = int'(sar_rd_pkg::frame_edges(SKIP_CLKS, DATA_W));
  localparam int CNT_W      = $clog2(FRAME_CLKS + 2);

  logic             rate_tick;
  logic             trigger;
  logic             load;
  logic             count_en;
  logic             toggle_en;
  logic             half_done;
  logic             rise_ev;
  logic             fall_ev;
  logic [CNT_W-1:0] rise_idx;
  logic             frame_end;
  logic             busy;

  assign trigger = start_i || rate_tick;

  sar_rd_rate_tick #(.RATE_W(RATE_W)) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (auto_en_i),
    .interval_i(rate_i),
    .tick_o    (rate_tick)
  );

  sar_rd_seq #(.CNT_W(CNT_W), .FRAME_CLKS(FRAME_CLKS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .trigger_i  (trigger),
    .rise_i     (rise_ev),
    .fall_i     (fall_ev),
    .half_done_i(half_done),
    .cs_n_o     (cs_n_o),
    .load_o     (load),
    .count_en_o (count_en),
    .toggle_en_o(toggle_en),
    .rise_idx_o (rise_idx),
    .frame_end_o(frame_end),
    .busy_o     (busy)
  );

  sar_rd_sclk_gen #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .div_i      (half_div_i),
    .count_en_i (count_en),
    .toggle_en_i(toggle_en),
    .sclk_o     (sclk_o),
    .half_done_o(half_done),
    .rise_o     (rise_ev),
    .fall_o     (fall_ev)
  );

  sar_rd_shifter #(.DATA_W(DATA_W), .SKIP_CLKS(SKIP_CLKS), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (rise_ev),
    .rise_idx_i(rise_idx),
    .sdi_i     (miso_i),
    .sample_o  (sample_o),
    .vld_o     (sample_vld_o),
    .err_o     (null_err_o)
  );

endmodule

// File: rtl/sar_rd_checker.sv
module sar_rd_checker #(
  parameter int CNT_W      = 5,
  parameter int FRAME_CLKS = 22,
  parameter int MIN_DIV    = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             vld,
  input logic             rise_ev,
  input logic [CNT_W-1:0] rise_idx,
  input logic             busy
);

  assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_select_only_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_edge_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |-> (rise_idx <= CNT_W'(FRAME_CLKS)));

  assert_release_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $fell(sclk));

  assert_strobe_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> ($rose(sclk) && !cs_n));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);

  assert_gap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  generate
    if (MIN_DIV >= 1) begin : g_min_half
      assert_min_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != $past(sclk)) |=> $stable(sclk));
    end
  endgenerate

endmodule

bind sar_rd_ctrl sar_rd_checker #(
  .CNT_W(CNT_W), .FRAME_CLKS(FRAME_CLKS), .MIN_DIV(MIN_DIV)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n_o),
  .sclk    (sclk_o),
  .vld     (sample_vld_o),
  .rise_ev (rise_ev),
  .rise_idx(rise_idx),
  .busy    (busy)
);

// File: tb/sim_sar_rd_ctrl.sv
`timescale 1ns/1ps
module sim_sar_rd_ctrl;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic               auto_en_i = 1'b0;
  logic [19:0]        rate_i = '0;
  logic [7:0]         half_div_i = 8'd1;
  logic               miso_i = 1'b1;
  logic               cs_n_o, sclk_o, sample_vld_o, null_err_o;
  logic signed [15:0] sample_o;

  always #5 clk = ~clk;

  sar_rd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_en_i(auto_en_i),
    .rate_i(rate_i), .half_div_i(half_div_i), .miso_i(miso_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sample_o(sample_o),
    .sample_vld_o(sample_vld_o), .null_err_o(null_err_o)
  );

  int checks = 0;
  int failures = 0;

  // converter model: drives on data-clock falls, noise while deselected
  logic [15:0] mdl_word = '0;
  logic        mdl_guard = 1'b0;
  logic        mdl_noise = 1'b0;
  logic        mdl_prev = 1'b0;
  int          mdl_falls = 0;
  always @(negedge clk) begin
    if (cs_n_o) begin
      mdl_falls = 0;
      miso_i = mdl_noise ? ~miso_i : 1'b1;
    end else if (mdl_prev && !sclk_o) begin
      mdl_falls = mdl_falls + 1;
      if (mdl_falls == 5)                         miso_i = mdl_guard;
      else if (mdl_falls >= 6 && mdl_falls <= 21) miso_i = mdl_word[21 - mdl_falls];
      else                                        miso_i = 1'b1;
    end
    mdl_prev = sclk_o;
  end

  // port monitor
  int cyc = 0, n_fall = 0, n_vld = 0, n_rise = 0, last_rises = 0;
  int t_fall = 0, t_r1 = 0, t_r2 = 0, t_csr = 0, t_vld = 0;
  int spacing = 0, high_len = 0;
  logic prev_cs = 1'b1, prev_sc = 1'b0;
  logic signed [15:0] last_val = '0;
  logic last_err = 1'b0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (prev_cs && !cs_n_o) begin
      n_fall = n_fall + 1; spacing = cyc - t_fall; t_fall = cyc;
      high_len = cyc - t_csr; n_rise = 0;
    end
    if (!prev_cs && cs_n_o) begin t_csr = cyc; last_rises = n_rise; end
    if (!prev_sc && sclk_o) begin
      n_rise = n_rise + 1;
      if (n_rise == 1) t_r1 = cyc;
      if (n_rise == 2) t_r2 = cyc;
    end
    if (sample_vld_o) begin
      n_vld = n_vld + 1; t_vld = cyc; last_val = sample_o; last_err = null_err_o;
    end
    prev_cs = cs_n_o; prev_sc = sclk_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hp_of(input int div);
    return ((div < 1) ? 1 : div) + 1;
  endfunction

  task automatic wait_idle(input int hp);
    while (!cs_n_o) @(negedge clk);
    repeat (2 * hp + 3) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // one frame, full timing and data checks (R3 R4 R5 R6 R7)
  task automatic t_frame(input logic [15:0] w, input logic g, input int div);
    int hp, v0;
    hp = hp_of(div);
    mdl_word = w; mdl_guard = g; half_div_i = 8'(div);
    v0 = n_vld;
    pulse_start();
    half_div_i = 8'd6;            // mid-frame change must not matter (R3)
    for (int i = 0; i < 4000 && n_vld == v0; i++) @(negedge clk);
    wait_idle(hp);
    chk(n_vld == v0 + 1, "R6 one strobe per frame", n_vld - v0, 1);
    chk(last_val == $signed(w), "R5 word", int'(last_val), int'($signed(w)));
    chk(last_err == g, "R7 guard flag", int'(last_err), int'(g));
    chk(last_rises == 22, "R4 rising edges", last_rises, 22);
    chk(t_r1 - t_fall == hp, "R3 select to first rise", t_r1 - t_fall, hp);
    chk(t_r2 - t_r1 == 2 * hp, "R3 clock period", t_r2 - t_r1, 2 * hp);
    chk(t_csr - t_r1 == 43 * hp, "R4 release after last fall", t_csr - t_r1, 43 * hp);
    chk(t_vld - t_r1 == 42 * hp, "R6 strobe at 22nd rise", t_vld - t_r1, 42 * hp);
  endtask

  task automatic t_reset();
    chk(cs_n_o == 1'b1, "R1 cs_n", int'(cs_n_o), 1);
    chk(sclk_o == 1'b0, "R1 sclk", int'(sclk_o), 0);
    chk(sample_vld_o == 1'b0, "R1 strobe", int'(sample_vld_o), 0);
    chk(sample_o == 16'sd0, "R1 sample", int'(sample_o), 0);
    chk(null_err_o == 1'b0, "R1 flag", int'(null_err_o), 0);
  endtask

  // R8: start during frame and during gap dropped; gap length with start held
  task automatic t_busy_and_gap();
    int f0, v0;
    mdl_word = 16'h1234; mdl_guard = 1'b0; half_div_i = 8'd1;
    f0 = n_fall; v0 = n_vld;
    pulse_start();
    repeat (30) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    while (!cs_n_o) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;   // lands in the gap
    repeat (150) @(negedge clk);
    chk(n_fall == f0 + 1, "R8 starts dropped while busy", n_fall - f0, 1);
    chk(n_vld == v0 + 1, "R8 one result", n_vld - v0, 1);
    f0 = n_fall;
    @(negedge clk); start_i = 1'b1;
    while (n_fall < f0 + 2) @(negedge clk);
    start_i = 1'b0;
    chk(high_len == 2 * 2 + 1, "R8 gap length", high_len, 5);
    wait_idle(2);
  endtask

  // R9: periodic frames
  task automatic t_auto(input int n, input int expect_sp);
    int f0;
    half_div_i = 8'd1; mdl_word = 16'h0F0F; rate_i = 20'(n);
    f0 = n_fall;
    @(negedge clk); auto_en_i = 1'b1;
    while (n_fall < f0 + 3) @(negedge clk);
    auto_en_i = 1'b0;
    chk(spacing == expect_sp, "R9 frame spacing", spacing, expect_sp);
    wait_idle(2);
  endtask

  // R11: start pulse and tick at the same edge
  task automatic t_coincide();
    int f0, v0;
    half_div_i = 8'd1; mdl_word = 16'hBEEF; mdl_guard = 1'b0; rate_i = 20'd300;
    f0 = n_fall; v0 = n_vld;
    @(negedge clk); auto_en_i = 1'b1;
    repeat (300) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (250) @(negedge clk);
    auto_en_i = 1'b0;
    chk(n_fall == f0 + 1, "R11 single frame", n_fall - f0, 1);
    chk(n_vld == v0 + 1, "R11 single strobe", n_vld - v0, 1);
    chk(last_val == $signed(16'hBEEF), "R11 word", int'(last_val), int'($signed(16'hBEEF)));
    wait_idle(2);
  endtask

  // R10: data line activity while deselected
  task automatic t_idle_noise();
    int v0;
    logic signed [15:0] keep;
    v0 = n_vld; keep = sample_o;
    mdl_noise = 1'b1;
    repeat (120) @(negedge clk);
    mdl_noise = 1'b0;
    chk(n_vld == v0, "R10 no strobe when deselected", n_vld - v0, 0);
    chk(sample_o == keep, "R10 sample held", int'(sample_o), int'(keep));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_frame(16'hA5C3, 1'b0, 1);   // R5 mixed pattern
    t_frame(16'h7FFF, 1'b0, 1);   // R5 largest positive
    t_frame(16'h8000, 1'b0, 3);   // R5 most negative, slower clock R3
    t_frame(16'h0000, 1'b1, 2);   // R7 bad guard bit
    t_frame(16'hFFFF, 1'b0, 0);   // R3 clamp of divider 0
    t_busy_and_gap();
    t_auto(199, 200);             // R9 tick slower than frame
    t_auto(49, 100);              // R9 ticks dropped while busy
    t_coincide();
    t_idle_noise();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule